// File: doc/BRIEF.md
# Flash Completion Status Poller

This block sits on the host side of a parallel NOR flash. After software or another engine has issued a program or erase command sequence, a one-cycle start pulse hands the poller the kind of operation, the checking method, the byte address being modified and the byte that should end up there. The poller then reads that address over and over through a simple request/acknowledge read port. It stops when the device's status bits show that the internal operation has finished, or when a cycle budget runs out.

Two ways of judging completion can be selected. The first watches bit 7 of each read. During a program this bit reads inverted against the expected data. During an erase it reads as zero. The second watches bit 6, which flips on every read while the device is busy and holds still once it is idle. Once completion is seen, the lower data bits may still lag the status bit. The poller therefore always makes one more read and judges that byte. It compares it with the expected byte for a program, or with the erased value for an erase. A protected sector that silently refused the change shows up as a fail.

Top module: `flash_poll_engine`

## Requirements
- R1: While a read is requested, rd_req stays high and rd_addr stays equal to the start address until rd_ack. rd_req is low for at least one cycle after each acknowledged read, and every read of a job uses the start address.
- R2: Data method (start_method=0) with a program (start_op=0): a read whose bit 7 equals bit 7 of the expected byte signals completion. A read showing the inverse of that bit keeps polling.
- R3: Data method with an erase (start_op=1): a read with bit 7 at 0 keeps polling, and bit 7 at 1 signals completion.
- R4: Toggle method (start_method=1): the first read of a job is only a reference. Completion is signalled when bit 6 of a read equals bit 6 of the read just before it, and differing values keep polling.
- R5: After completion is signalled, exactly one further read is made, and that byte is reported on final_data.
- R6: With the result, pass=1 and fail=0 when the final byte equals the expected byte (program) or FFh (erase). Otherwise pass=0 and fail=1, as for a protected sector left unchanged.
- R7: When a poll read returns without completion and at least timeout_cycles cycles have passed since start, the job ends at once with timed_out=1, fail=1 and pass=0, and no confirming read is made.
- R8: done is a single-cycle pulse. pass, fail, timed_out and final_data hold from done until the next accepted start, and a start pulse while busy is ignored.
- R9: After reset the block is idle: busy, rd_req, done, pass, fail and timed_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_op | input | 1 | 0 program, 1 erase |
| start_method | input | 1 | 0 bit-7 data check, 1 bit-6 toggle check |
| start_addr | input | AW | Byte address inside the sector being modified |
| start_data | input | 8 | Expected byte for a program |
| timeout_cycles | input | TW | Cycle budget for polling |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | One-cycle acknowledge with read data |
| rd_data | input | 8 | Byte returned by the read |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Final byte matched the target |
| fail | output | 1 | Mismatch or timeout |
| timed_out | output | 1 | Job ended by the cycle budget |
| final_data | output | 8 | Byte from the last read of the job |

## Verification
A behavioural flash model returns a chosen number of busy status bytes, then the settled contents. The data-method runs cover program and erase jobs with zero and several busy reads. The completing read carries corrupted low bits, so the test separates a poller that judges the confirming read from one that trusts the status read. Toggle runs set bit 6 of the settled data against the last busy value, which fixes the exact read count and exposes an off-by-one in the reference handling. Protected-sector runs, an erase that ends short of FFh, a device that never finishes, and a stray start pulse mid-job separate pass, fail and timeout and show that a busy job is never disturbed.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef enum logic {
        CHK_DATA   = 1'b0,
        CHK_TOGGLE = 1'b1
    } chk_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_POLL_GAP,
        ST_CONF_GAP,
        ST_CONF
    } st_e;

    typedef struct packed {
        op_e        op;
        chk_e       chk;
        logic [7:0] expect_byte;
    } job_t;

    localparam int         STATUS_BIT = 7;
    localparam int         TOGGLE_BIT = 6;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic logic [7:0] target_byte(job_t j);
        return (j.op == OP_ERASE) ? ERASED_BYTE : j.expect_byte;
    endfunction

endpackage

// File: rtl/fpe_judge.sv
module fpe_judge
    import fpe_pkg::*;
(
    input  job_t       job,
    input  logic [7:0] rd_byte,
    input  logic       ref_valid,
    input  logic       ref_bit,
    output logic       complete
);
    logic data_done;
    logic toggle_done;

    always_comb begin
        if (job.op == OP_ERASE)
            data_done = rd_byte[STATUS_BIT];
        else
            data_done = (rd_byte[STATUS_BIT] == job.expect_byte[STATUS_BIT]);
        toggle_done = ref_valid && (rd_byte[TOGGLE_BIT] == ref_bit);
        complete    = (job.chk == CHK_TOGGLE) ? toggle_done : data_done;
    end

endmodule

// File: rtl/fpe_timer.sv
module fpe_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt;
    logic [TW-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            limit_q <= '0;
        end else if (clear) begin
            cnt     <= '0;
            limit_q <= limit;
        end else if (run && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit_q);

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        clear |=> !run || cnt <= 1); // R7

endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
    import fpe_pkg::*;
#(
    parameter int AW = 18,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_op,
    input  logic          start_method,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    input  logic [TW-1:0] timeout_cycles,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          timed_out,
    output logic [7:0]    final_data
);
    st_e           st;
    job_t          job;
    logic [AW-1:0] addr_q;
    logic          ref_valid;
    logic          ref_bit;
    logic          complete;
    logic          expired;
    logic          accept;

    assign accept = start && (st == ST_IDLE);

    fpe_judge u_judge (
        .job       (job),
        .rd_byte   (rd_data),
        .ref_valid (ref_valid),
        .ref_bit   (ref_bit),
        .complete  (complete)
    );

    fpe_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .run     (st != ST_IDLE),
        .limit   (timeout_cycles),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            job        <= '0;
            addr_q     <= '0;
            ref_valid  <= 1'b0;
            ref_bit    <= 1'b0;
            done       <= 1'b0;
            pass       <= 1'b0;
            fail       <= 1'b0;
            timed_out  <= 1'b0;
            final_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    job.op          <= op_e'(start_op);
                    job.chk         <= chk_e'(start_method);
                    job.expect_byte <= start_data;
                    addr_q          <= start_addr;
                    ref_valid       <= 1'b0;
                    pass            <= 1'b0;
                    fail            <= 1'b0;
                    timed_out       <= 1'b0;
                    st              <= ST_POLL;
                end
                ST_POLL: if (rd_ack) begin
                    ref_valid <= 1'b1;
                    ref_bit   <= rd_data[TOGGLE_BIT];
                    if (complete) begin
                        st <= ST_CONF_GAP;
                    end else if (expired) begin
                        done       <= 1'b1;
                        fail       <= 1'b1;
                        timed_out  <= 1'b1;
                        final_data <= rd_data;
                        st         <= ST_IDLE;
                    end else begin
                        st <= ST_POLL_GAP;
                    end
                end
                ST_POLL_GAP: st <= ST_POLL;
                ST_CONF_GAP: st <= ST_CONF;
                ST_CONF: if (rd_ack) begin
                    final_data <= rd_data;
                    done       <= 1'b1;
                    pass       <= (rd_data == target_byte(job));
                    fail       <= (rd_data != target_byte(job));
                    st         <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st != ST_IDLE);
    assign rd_req  = (st == ST_POLL) || (st == ST_CONF);
    assign rd_addr = addr_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack |=> rd_req); // R1
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(rd_addr)); // R1
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_ack |=> !rd_req); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !rd_req); // R8
    AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass ^ fail)); // R6
    AST_TMO_IS_FAIL: assert property (@(posedge clk) disable iff (rst)
        timed_out |-> fail && !pass); // R7
    AST_PROG_PASS_MATCH: assert property (@(posedge clk) disable iff (rst)
        done && pass && job.op == OP_PROGRAM |-> final_data == job.expect_byte); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy && !start && $past(!busy) |=> $stable(pass) && $stable(final_data)); // R8

endmodule

// File: tb/flash_poll_engine_test.sv
module flash_poll_engine_test;
    localparam int AW = 18;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          start_op = 1'b0;
    logic          start_method = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    start_data = '0;
    logic [TW-1:0] timeout_cycles = 16'd1000;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          busy, done, pass, fail, timed_out;
    logic [7:0]    final_data;

    always #5 clk = ~clk;

    flash_poll_engine #(.AW(AW), .TW(TW)) uut (
        .clk(clk), .rst(rst), .start(start), .start_op(start_op),
        .start_method(start_method), .start_addr(start_addr),
        .start_data(start_data), .timeout_cycles(timeout_cycles),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .pass(pass), .fail(fail),
        .timed_out(timed_out), .final_data(final_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // flash model settings
    int            m_busy_reads = 0;
    logic [7:0]    m_true = '0;
    logic [7:0]    m_exp  = '0;
    logic          m_op = 1'b0;
    logic          m_method = 1'b0;
    logic [AW-1:0] m_addr = '0;
    int            m_reads = 0;
    int            m_bad_addr = 0;
    int            m_no_hold = 0;
    int            m_no_gap = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] model_byte(input int k);
        logic [7:0] b;
        if (k < m_busy_reads) begin
            if (m_method) begin
                b = 8'h0C;
                b[6] = (((m_busy_reads - 1 - k) % 2) == 0) ? ~m_true[6] : m_true[6];
            end else if (m_op) begin
                b = 8'h55;
            end else begin
                b = {~m_exp[7], 7'h2A};
            end
        end else if (k == m_busy_reads && !m_method) begin
            b = {m_true[7], m_true[6:0] ^ 7'h7F};
        end else begin
            b = m_true;
        end
        return b;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (rd_req) begin
                if (rd_addr !== m_addr) m_bad_addr++;
                repeat (2) begin
                    @(negedge clk);
                    if (!rd_req || rd_addr !== m_addr) m_no_hold++;
                end
                rd_data = model_byte(m_reads);
                rd_ack  = 1'b1;
                @(negedge clk);
                rd_ack  = 1'b0;
                m_reads++;
                if (rd_req) m_no_gap++;
            end
        end
    end

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic launch(input logic op, input logic method, input logic [AW-1:0] addr,
                          input logic [7:0] expv, input logic [TW-1:0] limit);
        @(negedge clk);
        start_op = op; start_method = method; start_addr = addr;
        start_data = expv; timeout_cycles = limit; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_job(input string req, input logic op, input logic method,
                           input logic [7:0] expv, input logic [7:0] truev, input int nbusy,
                           input int exp_reads, input logic exp_pass, input bit poke);
        bit seen;
        m_busy_reads = nbusy; m_true = truev; m_exp = expv; m_op = op; m_method = method;
        m_addr = 18'h1A5C3 ^ AW'(nbusy); m_reads = 0;
        m_bad_addr = 0; m_no_hold = 0; m_no_gap = 0;
        launch(op, method, m_addr, expv, 16'd5000);
        if (poke) begin
            repeat (5) @(negedge clk);
            start_op = ~op; start_method = ~method; start_addr = ~m_addr;
            start_data = ~expv; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(seen);
        check({req, " done seen"}, 32'(seen), 32'd1);
        check({req, " pass"}, 32'(pass), 32'(exp_pass));
        check({req, " fail"}, 32'(fail), 32'(!exp_pass));
        check({req, " timed_out"}, 32'(timed_out), 32'd0);
        check({req, " final_data"}, 32'(final_data), 32'(truev));
        @(negedge clk);
        check("R8 done single pulse", 32'(done), 32'd0);
        check({req, " read count"}, 32'(m_reads), 32'(exp_reads));
        check("R1 address per read", 32'(m_bad_addr), 32'd0);
        check("R1 request held", 32'(m_no_hold), 32'd0);
        check("R1 gap after read", 32'(m_no_gap), 32'd0);
        repeat (3) @(negedge clk);
        check("R8 result held", 32'({pass, final_data}), 32'({exp_pass, truev}));
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset outputs",
              32'({busy, rd_req, done, pass, fail, timed_out}), 32'd0);
    endtask

    task automatic test_timeout();
        bit seen;
        m_busy_reads = 100000; m_true = 8'h3C; m_exp = 8'h3C; m_op = 1'b0; m_method = 1'b0;
        m_addr = 18'h00777; m_reads = 0;
        launch(1'b0, 1'b0, m_addr, 8'h3C, 16'd30);
        wait_done(seen);
        check("R7 done on timeout", 32'(seen), 32'd1);
        check("R7 timed_out", 32'(timed_out), 32'd1);
        check("R7 fail", 32'(fail), 32'd1);
        check("R7 pass", 32'(pass), 32'd0);
        check("R7 last poll byte kept", 32'(final_data), 32'h AA);
        @(negedge clk);
        check("R7 no confirm read", 32'(rd_req || busy), 32'd0);
        n_checks++;
        if (m_reads < 3 || m_reads > 12) begin
            n_fail++;
            $display("FAIL R7 poll reads before timeout: actual %0d expected 3..12", m_reads);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        test_reset();
        // R2/R5: program, three busy reads, low bits lag on the completing read
        run_job("R2 R5 program data", 1'b0, 1'b0, 8'h3C, 8'h3C, 3, 5, 1'b1, 1'b0);
        // R2: already complete on first read
        run_job("R2 program immediate", 1'b0, 1'b0, 8'hC7, 8'hC7, 0, 2, 1'b1, 1'b0);
        // R3: erase, four busy reads
        run_job("R3 erase data", 1'b1, 1'b0, 8'h00, 8'hFF, 4, 6, 1'b1, 1'b0);
        // R6: erase ends with a byte that is not FFh
        run_job("R6 erase short", 1'b1, 1'b0, 8'h00, 8'hFE, 2, 4, 1'b0, 1'b0);
        // R4: toggle program
        run_job("R4 toggle program", 1'b0, 1'b1, 8'h81, 8'h81, 5, 8, 1'b1, 1'b0);
        run_job("R4 toggle short", 1'b0, 1'b1, 8'h5A, 8'h5A, 1, 4, 1'b1, 1'b0);
        // R6: protected sector, data unchanged
        run_job("R6 protected program", 1'b0, 1'b1, 8'h3C, 8'hA5, 1, 4, 1'b0, 1'b0);
        run_job("R6 protected erase", 1'b1, 1'b1, 8'h00, 8'h00, 2, 5, 1'b0, 1'b0);
        // R8: start while busy is ignored
        run_job("R8 start ignored", 1'b1, 1'b0, 8'h00, 8'hFF, 6, 8, 1'b1, 1'b1);
        test_timeout();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule